// File: doc/BRIEF.md
# Two-Wire Bus Stuck-Line Watchdog with Recovery Sequencer

This block guards one downstream two-wire bus port against a line held low. It watches the clock and data lines and runs one timer per line. Each timer counts how long its line has been low without a break. A free-running prescaler makes a slow tick, and both timers count in ticks. If the clock line stays low past a programmable tick limit (35 ticks after reset, which is 35 ms with a 1 ms tick), the block latches a clock-stuck interrupt. If the data line stays low past a fixed, longer limit, it latches a data-stuck interrupt. Each latch can be armed separately.

A latched interrupt stays set until a port reset completes. On request, a sequencer drives the bus open-drain: it toggles the clock nine times while leaving data released, then forms a stop condition. That condition is data pulled low under a low clock, then clock released, then data released. When the sequence finishes, both latches and both timers clear. During the sequence the timers are held at zero, so the block's own clock pulses never count as a stuck line.

Top module: `bus_stuck_guard`

## Requirements
- R1: Once the synchronised clock line has been low for `scl_limit` ticks without interruption, and `scl_irq_en` is 1, `scl_stuck_irq` goes to 1. A shorter low period leaves it at 0.
- R2: The clock limit is 35 ticks after reset. A one-cycle pulse on `scl_limit_wr` loads `scl_limit_val` as the new limit.
- R3: Once the synchronised data line has been low for `SDA_LIMIT_TICKS` ticks without interruption, and `sda_irq_en` is 1, `sda_stuck_irq` goes to 1. The clock interrupt is not affected.
- R4: A line sampled high restarts its timer from zero. Separate low periods, each shorter than the limit, never add up to an interrupt.
- R5: While an enable is 0, its line's timeout is ignored and its interrupt stays 0. Setting the enable to 1 afterwards, with the line already high, does not raise the interrupt.
- R6: A raised interrupt stays at 1 after its line goes high again, until a port reset completes.
- R7: A pulse on `port_reset_req` while idle starts the recovery and holds `recover_busy` at 1 until it ends. During recovery `scl_pull` (1 = drive clock low) releases the clock exactly nine times.
- R8: `sda_pull` (1 = drive data low) is asserted exactly once per recovery, and only while the clock is driven low. It is released only while the clock is released, which forms a stop condition and never a start condition.
- R9: When recovery ends, both interrupts clear one cycle after `recover_busy` falls, and both timers restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sensed clock line level |
| sda_in | input | 1 | Sensed data line level |
| scl_limit_wr | input | 1 | Load strobe for the clock limit |
| scl_limit_val | input | LIM_W | New clock limit in ticks |
| scl_irq_en | input | 1 | Arms the clock-stuck interrupt |
| sda_irq_en | input | 1 | Arms the data-stuck interrupt |
| port_reset_req | input | 1 | Starts the recovery sequence |
| scl_pull | output | 1 | 1 drives the clock line low |
| sda_pull | output | 1 | 1 drives the data line low |
| recover_busy | output | 1 | Recovery sequence in progress |
| scl_stuck_irq | output | 1 | Latched clock-stuck interrupt |
| sda_stuck_irq | output | 1 | Latched data-stuck interrupt |

## Verification
The bench builds the block with the following parameter values:

| Parameter | Bench value | What it brings within reach |
|---|---|---|
| `CLK_PER_TICK` | 4 | A few hundred cycles cover the 35-tick reset limit, so it can be checked from both sides. |
| `SDA_LIMIT_TICKS` | 20 | A data-line timeout can be reached directly, within a short run. |
| `HALF_PER` | 3 | A whole recovery sequence, all nine releases plus the stop, takes about sixty cycles. |

A written limit of 5 ticks lets the bench show that separate low periods do not add up. Each of them stays one tick below the limit.

// File: rtl/bus_stuck_pkg.sv
package bus_stuck_pkg;
    typedef enum logic [2:0] {
        RS_IDLE,
        RS_LOW,
        RS_HIGH,
        RS_STOP_SETUP,
        RS_STOP_SCL,
        RS_STOP_SDA
    } rec_state_e;

    localparam int unsigned RECOVER_PULSES = 9;
endpackage

// File: rtl/bus_tick_gen.sv
module bus_tick_gen #(
    parameter int unsigned CLK_PER_TICK = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    if (CLK_PER_TICK > 1) begin : g_chk
        // R1: ticks are isolated single-cycle pulses
        a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
    end
endmodule

// File: rtl/low_span_timer.sv
module low_span_timer #(
    parameter int unsigned LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             tick,
    input  logic             clear,
    input  logic [LIM_W-1:0] limit,
    output logic             expired
);
    typedef struct packed {
        logic [1:0]       sync;
        logic [LIM_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    line_s;

    assign line_s = st_q.sync[1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], line_in};
        if (clear || line_s) begin
            st_d.cnt = '0;
        end else if (tick && (st_q.cnt < limit)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= 2'b11;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = !line_s && !clear && (st_q.cnt >= limit);

    // R4: a high sample restarts the span
    a_r4_high_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        line_s |=> (st_q.cnt == '0));
    // R1: the span grows by one step at most, or restarts
    a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != $past(st_q.cnt)) |->
            ((st_q.cnt == $past(st_q.cnt) + 1'b1) || (st_q.cnt == '0)));
endmodule

// File: rtl/bus_recover_seq.sv
module bus_recover_seq
    import bus_stuck_pkg::*;
#(
    parameter int unsigned HALF_PER = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic scl_pull,
    output logic sda_pull,
    output logic busy,
    output logic done
);
    localparam int unsigned HW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_PER - 1);
    localparam logic [3:0] LAST_PULSE = 4'(RECOVER_PULSES - 1);

    typedef struct packed {
        rec_state_e    st;
        logic [HW-1:0] tmr;
        logic [3:0]    pulses;
        logic          done;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    tmr_end;

    assign tmr_end = (st_q.tmr == HALF_LAST);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.st == RS_IDLE) begin
            if (start) begin
                st_d.st     = RS_LOW;
                st_d.tmr    = '0;
                st_d.pulses = '0;
            end
        end else if (!tmr_end) begin
            st_d.tmr = st_q.tmr + 1'b1;
        end else begin
            st_d.tmr = '0;
            case (st_q.st)
                RS_LOW:        st_d.st = (st_q.pulses == LAST_PULSE) ? RS_STOP_SETUP : RS_HIGH;
                RS_HIGH: begin
                    st_d.st     = RS_LOW;
                    st_d.pulses = st_q.pulses + 1'b1;
                end
                RS_STOP_SETUP: st_d.st = RS_STOP_SCL;
                RS_STOP_SCL:   st_d.st = RS_STOP_SDA;
                RS_STOP_SDA: begin
                    st_d.st   = RS_IDLE;
                    st_d.done = 1'b1;
                end
                default:       st_d.st = RS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st     <= RS_IDLE;
            st_q.tmr    <= '0;
            st_q.pulses <= '0;
            st_q.done   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_pull = (st_q.st == RS_LOW) || (st_q.st == RS_STOP_SETUP);
    assign sda_pull = (st_q.st == RS_STOP_SETUP) || (st_q.st == RS_STOP_SCL);
    assign busy     = (st_q.st != RS_IDLE);
    assign done     = st_q.done;

    // R8: data is only grabbed under a low clock
    a_r8_grab_under_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> scl_pull);
    // R8: data is only let go under a released clock
    a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> !scl_pull);
    // R7: pulse counter stays inside the nine pulses
    a_r7_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulses < 4'(RECOVER_PULSES));
    // R9: completion only follows the stop phase
    a_r9_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(st_q.st == RS_STOP_SDA));
endmodule

// File: rtl/bus_stuck_guard.sv
module bus_stuck_guard #(
    parameter int unsigned CLK_PER_TICK    = 100000,
    parameter int unsigned LIM_W           = 16,
    parameter int unsigned SCL_LIMIT_RST   = 35,
    parameter int unsigned SDA_LIMIT_TICKS = 1000,
    parameter int unsigned HALF_PER        = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             scl_limit_wr,
    input  logic [LIM_W-1:0] scl_limit_val,
    input  logic             scl_irq_en,
    input  logic             sda_irq_en,
    input  logic             port_reset_req,
    output logic             scl_pull,
    output logic             sda_pull,
    output logic             recover_busy,
    output logic             scl_stuck_irq,
    output logic             sda_stuck_irq
);
    localparam logic [LIM_W-1:0] SCL_LIM_INIT = LIM_W'(SCL_LIMIT_RST);
    localparam logic [LIM_W-1:0] SDA_LIM      = LIM_W'(SDA_LIMIT_TICKS);

    typedef struct packed {
        logic [LIM_W-1:0] scl_lim;
        logic             scl_flag;
        logic             sda_flag;
    } guard_st_t;

    guard_st_t st_d, st_q;
    logic tick, scl_exp, sda_exp, rec_done, tmr_clear;

    assign tmr_clear = recover_busy || rec_done;

    bus_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) i_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    low_span_timer #(.LIM_W(LIM_W)) i_scl_tmr (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in), .tick(tick),
        .clear(tmr_clear), .limit(st_q.scl_lim), .expired(scl_exp)
    );

    low_span_timer #(.LIM_W(LIM_W)) i_sda_tmr (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in), .tick(tick),
        .clear(tmr_clear), .limit(SDA_LIM), .expired(sda_exp)
    );

    bus_recover_seq #(.HALF_PER(HALF_PER)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(port_reset_req),
        .scl_pull(scl_pull), .sda_pull(sda_pull),
        .busy(recover_busy), .done(rec_done)
    );

    always_comb begin
        st_d = st_q;
        if (scl_limit_wr) st_d.scl_lim = scl_limit_val;
        if (rec_done) begin
            st_d.scl_flag = 1'b0;
            st_d.sda_flag = 1'b0;
        end else begin
            st_d.scl_flag = st_q.scl_flag || (scl_exp && scl_irq_en);
            st_d.sda_flag = st_q.sda_flag || (sda_exp && sda_irq_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.scl_lim  <= SCL_LIM_INIT;
            st_q.scl_flag <= 1'b0;
            st_q.sda_flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_stuck_irq = st_q.scl_flag;
    assign sda_stuck_irq = st_q.sda_flag;

    // R5: an interrupt only rises while its enable was set
    a_r5_scl_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_stuck_irq) |-> $past(scl_irq_en));
    a_r5_sda_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_stuck_irq) |-> $past(sda_irq_en));
    // R6: latched interrupts hold until recovery completes
    a_r6_scl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_stuck_irq && !rec_done) |=> scl_stuck_irq);
    a_r6_sda_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_stuck_irq && !rec_done) |=> sda_stuck_irq);
    // R9: completion clears both interrupts
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |=> (!scl_stuck_irq && !sda_stuck_irq));
    // R9: no interrupt rises while recovery runs
    a_r9_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        recover_busy |=> !$rose(scl_stuck_irq) && !$rose(sda_stuck_irq));
endmodule

// File: tb/test_bus_stuck_guard.sv
module test_bus_stuck_guard;
    localparam int unsigned LIM_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_hold = 1'b0, sda_hold = 1'b0;
    logic scl_limit_wr = 1'b0;
    logic [LIM_W-1:0] scl_limit_val = '0;
    logic scl_irq_en = 1'b1, sda_irq_en = 1'b1;
    logic port_reset_req = 1'b0;
    logic scl_pull, sda_pull, recover_busy, scl_stuck_irq, sda_stuck_irq;
    logic scl_in, sda_in;

    int checks = 0;
    int failures = 0;
    int rel_cnt = 0, sda_grab_cnt = 0, order_bad = 0;
    logic prev_scl = 1'b0, prev_sda = 1'b0;

    assign scl_in = !(scl_hold || scl_pull);
    assign sda_in = !(sda_hold || sda_pull);

    always #2.5 clk = !clk;

    bus_stuck_guard #(
        .CLK_PER_TICK(4), .LIM_W(LIM_W), .SCL_LIMIT_RST(35),
        .SDA_LIMIT_TICKS(20), .HALF_PER(3)
    ) i_bus_stuck_guard (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_limit_wr(scl_limit_wr), .scl_limit_val(scl_limit_val),
        .scl_irq_en(scl_irq_en), .sda_irq_en(sda_irq_en),
        .port_reset_req(port_reset_req), .scl_pull(scl_pull), .sda_pull(sda_pull),
        .recover_busy(recover_busy), .scl_stuck_irq(scl_stuck_irq),
        .sda_stuck_irq(sda_stuck_irq)
    );

    // Observe the recovery waveform at the inactive edge
    always @(negedge clk) begin
        if (prev_scl && !scl_pull) rel_cnt++;
        if (!prev_sda && sda_pull) begin
            sda_grab_cnt++;
            if (!scl_pull) order_bad++;
        end
        if (prev_sda && !sda_pull && scl_pull) order_bad++;
        prev_scl = scl_pull;
        prev_sda = sda_pull;
    end

    task automatic chk(input logic cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic recover();
        rel_cnt = 0; sda_grab_cnt = 0; order_bad = 0;
        @(negedge clk) port_reset_req = 1'b1;
        @(negedge clk) port_reset_req = 1'b0;
        chk(recover_busy == 1'b1, "R7 busy after request", int'(recover_busy), 1);
        for (int i = 0; i < 500 && recover_busy; i++) @(negedge clk);
        idle(2);
        chk(rel_cnt == 9, "R7 clock releases", rel_cnt, 9);
        chk(sda_grab_cnt == 1 && order_bad == 0, "R8 stop ordering",
            sda_grab_cnt * 10 + order_bad, 10);
        chk(!scl_stuck_irq && !sda_stuck_irq, "R9 flags cleared",
            int'({scl_stuck_irq, sda_stuck_irq}), 0);
    endtask

    task automatic t_reset();
        chk(!scl_pull && !sda_pull && !recover_busy && !scl_stuck_irq && !sda_stuck_irq,
            "R7 reset outputs idle",
            int'({scl_pull, sda_pull, recover_busy, scl_stuck_irq, sda_stuck_irq}), 0);
    endtask

    task automatic t_default_limit();
        scl_hold = 1'b1; idle(120); scl_hold = 1'b0; idle(6);
        chk(!scl_stuck_irq, "R2 default limit not reached at 30 ticks", int'(scl_stuck_irq), 0);
        scl_hold = 1'b1; idle(170);
        chk(scl_stuck_irq, "R1 clock stuck past 35 ticks", int'(scl_stuck_irq), 1);
        chk(!sda_stuck_irq, "R3 data flag independent", int'(sda_stuck_irq), 0);
    endtask

    task automatic t_latched();
        scl_hold = 1'b0; idle(60);
        chk(scl_stuck_irq, "R6 flag held after release", int'(scl_stuck_irq), 1);
    endtask

    task automatic t_write_limit();
        @(negedge clk) begin scl_limit_val = 16'd5; scl_limit_wr = 1'b1; end
        @(negedge clk) scl_limit_wr = 1'b0;
        scl_hold = 1'b1; idle(12); scl_hold = 1'b0; idle(6);
        chk(!scl_stuck_irq, "R2 short low under written limit", int'(scl_stuck_irq), 0);
        scl_hold = 1'b1; idle(40); scl_hold = 1'b0; idle(4);
        chk(scl_stuck_irq, "R2 written limit reached", int'(scl_stuck_irq), 1);
        recover();
    endtask

    task automatic t_restart();
        for (int k = 0; k < 4; k++) begin
            scl_hold = 1'b1; idle(16); scl_hold = 1'b0; idle(8);
        end
        chk(!scl_stuck_irq, "R4 split lows do not accumulate", int'(scl_stuck_irq), 0);
    endtask

    task automatic t_enable();
        scl_irq_en = 1'b0;
        scl_hold = 1'b1; idle(60); scl_hold = 1'b0; idle(6);
        chk(!scl_stuck_irq, "R5 disabled clock timeout ignored", int'(scl_stuck_irq), 0);
        scl_irq_en = 1'b1; idle(20);
        chk(!scl_stuck_irq, "R5 late enable raises nothing", int'(scl_stuck_irq), 0);
    endtask

    task automatic t_sda();
        sda_hold = 1'b1; idle(60); sda_hold = 1'b0; idle(6);
        chk(!sda_stuck_irq, "R3 data low below limit", int'(sda_stuck_irq), 0);
        sda_hold = 1'b1; idle(120);
        chk(sda_stuck_irq, "R3 data stuck past limit", int'(sda_stuck_irq), 1);
        chk(!scl_stuck_irq, "R3 clock flag untouched", int'(scl_stuck_irq), 0);
        sda_hold = 1'b0; idle(20);
        chk(sda_stuck_irq, "R6 data flag held", int'(sda_stuck_irq), 1);
        recover();
    endtask

    task automatic t_sda_disabled();
        sda_irq_en = 1'b0;
        sda_hold = 1'b1; idle(120); sda_hold = 1'b0; idle(6);
        chk(!sda_stuck_irq, "R5 disabled data timeout ignored", int'(sda_stuck_irq), 0);
        sda_irq_en = 1'b1;
    endtask

    task automatic t_timer_restart_after_recovery();
        scl_hold = 1'b1; idle(12); scl_hold = 1'b0; idle(4);
        recover();
        scl_hold = 1'b1; idle(12); scl_hold = 1'b0; idle(6);
        chk(!scl_stuck_irq, "R9 timer restarted by recovery", int'(scl_stuck_irq), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_default_limit();
        t_latched();
        recover();
        t_write_limit();
        t_restart();
        t_enable();
        t_sda();
        t_sda_disabled();
        t_timer_restart_after_recovery();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule